// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion at a time for a converter whose analog parts sit outside it. A host requests a conversion with three control lines: chip enable, an active-low chip select and a read/convert line. A conversion starts when the combination "enable high, select low, read/convert low" becomes true. It does not start while that combination merely stays true. A mode line sampled at that moment chooses a full-width conversion or a narrow one. In the narrow mode only the upper bits are resolved and the two lowest result bits are zero.

After a start the sequencer waits through a fixed sampling window. It then issues a one-cycle hold strobe to the external sample-and-hold. Next it runs a burst of exactly thirteen conversion-clock periods and stops that clock again. During the burst it sets a trial word for the external DAC and reads a single comparator bit, working from the MSB down. An active-low end-of-conversion flag is high while a conversion runs. When the result register is loaded the flag drops and a one-cycle valid strobe is raised. A rate input chooses the normal conversion-clock period or one half as long.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts only when (ce_i high AND cs_n_i low AND rd_cnv_i low) goes from false to true. Any of the three lines can make that transition. Keeping the condition true after a conversion, or making only some of the three lines active, starts nothing.
- R2: The mode line a0_i is taken at the start. Low selects the 10-bit conversion and high selects the 8-bit conversion. Changes on a0_i during a conversion do not alter its mode.
- R3: In 8-bit mode result_o[9:2] holds the MSB-first approximation of the input and result_o[1:0] is 00.
- R4: In 10-bit mode the bits are resolved MSB first. Each bit is set on trial_o and kept when cmp_i is high, which means the input is at or above trial_o. Otherwise it is cleared. For an ideal comparator the result therefore equals the input code.
- R5: hold_o is high for exactly one cycle per conversion. That cycle is the SAMPLE_TICKS-th cycle in which eoc_n_o is high.
- R6: conv_clk_o stays low through the sampling window. It then runs for exactly CONV_CYCLES (13) periods and stays low until the next start.
- R7: When freq_norm_i is high at the start, one conversion-clock period is CONV_DIV system cycles. When it is low, a period is CONV_DIV/2 cycles. eoc_n_o is therefore high for SAMPLE_TICKS + 13 × period cycles.
- R8: eoc_n_o goes high when a start is accepted and stays high until the result register is loaded, then returns low.
- R9: result_valid_o pulses for one cycle in the cycle where eoc_n_o falls, which is also the cycle where result_o takes its new value. At all other times result_o holds its value.
- R10: While rst_n is low: result_o is 0, eoc_n_o is low, result_valid_o, hold_o and conv_clk_o are low, and the sequencer is idle.
- R11: A new start transition that arrives while a conversion is running is ignored. The running conversion keeps its length and produces exactly one result.
- R12: The control lines pass through SYNC_STAGES (2) synchronizer flops. eoc_n_o rises at the third rising clock edge after the start condition is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rd_cnv_i | input | 1 | Read/convert line; low requests a conversion |
| a0_i | input | 1 | Mode line: 0 = 10-bit, 1 = 8-bit |
| freq_norm_i | input | 1 | 1 = normal conversion-clock rate, 0 = double rate |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above trial_o |
| hold_o | output | 1 | One-cycle strobe that ends the sampling window |
| conv_clk_o | output | 1 | Gated conversion clock, 13-period burst |
| trial_o | output | 10 | Trial word for the external DAC |
| eoc_n_o | output | 1 | End of conversion, active low (high while busy) |
| result_o | output | 10 | Stored conversion result |
| result_valid_o | output | 1 | One-cycle strobe when result_o is loaded |

## Verification
The bench models an ideal comparator by comparing a chosen input code against trial_o. It then runs conversions with random codes, random modes, random rate settings and a random choice of which control line completes the start condition. Zero, full scale, the MSB-only code and a code with only the two low bits set tell MSB-first resolution apart from off-by-one bit ordering. They also show whether the 8-bit masking is applied. Measured busy length and hold position separate the two clock rates and expose a wrong sampling count. Toggling the mode and re-pulsing the start condition during a conversion, holding the condition afterwards and driving partial conditions show whether the start logic is edge-based and whether the mode is latched.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_CONV   = 2'd2
  } seq_state_e;

  // Length of one conversion-clock period in system cycles.
  function automatic int unsigned conv_period(input int unsigned base_div, input logic fast);
    return fast ? (base_div / 2) : base_div;
  endfunction

  // Total busy length of one conversion in system cycles.
  function automatic int unsigned busy_cycles(input int unsigned samp, input int unsigned bursts,
                                              input int unsigned base_div, input logic fast);
    return samp + bursts * conv_period(base_div, fast);
  endfunction

endpackage

// File: rtl/sar_ctl_sync.sv
module sar_ctl_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned NSIG   = 5,
  parameter logic [NSIG-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] async_i,
  output logic [NSIG-1:0] sync_o
);
  logic [STAGES-1:0][NSIG-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_burst_timer.sv
module sar_burst_timer
  import sar_seq_pkg::*;
#(
  parameter int unsigned SAMPLE_TICKS = 40,
  parameter int unsigned CONV_DIV     = 8,
  parameter int unsigned CONV_CYCLES  = 13,
  localparam int unsigned SW = $clog2(SAMPLE_TICKS + 1),
  localparam int unsigned DW = $clog2(CONV_DIV + 1),
  localparam int unsigned PW = $clog2(CONV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          mode_sel,
  input  logic          freq_norm,
  output logic          busy,
  output logic          hold,
  output logic          conv_clk,
  output logic          period_tick,
  output logic [PW-1:0] period_idx,
  output logic          burst_done,
  output logic          mode8
);
  seq_state_e    state_q;
  logic [SW-1:0] samp_q;
  logic [DW-1:0] div_q;
  logic [PW-1:0] per_q;
  logic          fast_q;
  logic [DW-1:0] plen;

  assign plen        = DW'(conv_period(CONV_DIV, fast_q));
  assign busy        = (state_q != SEQ_IDLE);
  assign hold        = (state_q == SEQ_SAMPLE) && (samp_q == SW'(SAMPLE_TICKS - 1));
  assign period_tick = (state_q == SEQ_CONV) && (div_q == plen - DW'(1));
  assign burst_done  = period_tick && (per_q == PW'(CONV_CYCLES - 1));
  assign conv_clk    = (state_q == SEQ_CONV) && (div_q < (plen >> 1));
  assign period_idx  = per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      samp_q  <= '0;
      div_q   <= '0;
      per_q   <= '0;
      fast_q  <= 1'b0;
      mode8   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_evt) begin
            state_q <= SEQ_SAMPLE;
            samp_q  <= '0;
            mode8   <= mode_sel;
            fast_q  <= ~freq_norm;
          end
        end
        SEQ_SAMPLE: begin
          if (hold) begin
            state_q <= SEQ_CONV;
            div_q   <= '0;
            per_q   <= '0;
          end else begin
            samp_q <= samp_q + SW'(1);
          end
        end
        SEQ_CONV: begin
          if (period_tick) begin
            div_q <= '0;
            if (burst_done) state_q <= SEQ_IDLE;
            else            per_q   <= per_q + PW'(1);
          end else begin
            div_q <= div_q + DW'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned NARROW_W    = 8,
  parameter int unsigned CONV_CYCLES = 13,
  localparam int unsigned PW  = $clog2(CONV_CYCLES + 1),
  localparam int unsigned CUT = RES_W - NARROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_tick,
  input  logic [PW-1:0]    period_idx,
  input  logic             burst_done,
  input  logic             mode8,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);
  logic [RES_W-1:0] sar_q;

  // Bits below the cut are never tried in narrow mode.
  function automatic logic [RES_W-1:0] keep_mask(input logic narrow);
    logic [RES_W-1:0] m;
    m = '1;
    if (narrow) m = m << CUT;
    return m;
  endfunction

  for (genvar gi = 0; gi < int'(RES_W); gi++) begin : g_bit
    logic active;
    logic set_evt;
    logic dec_evt;
    assign active = !mode8 || (gi >= int'(CUT));
    if (gi == int'(RES_W) - 1) begin : g_msb
      assign set_evt = 1'b0;
    end else begin : g_low
      assign set_evt = period_tick && active && (period_idx == PW'(RES_W - 1 - gi));
    end
    assign dec_evt = period_tick && active && (period_idx == PW'(RES_W - gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sar_q[gi] <= 1'b0;
      else if (period_tick && period_idx == '0)    sar_q[gi] <= (gi == int'(RES_W) - 1);
      else if (set_evt)                            sar_q[gi] <= 1'b1;
      else if (dec_evt)                            sar_q[gi] <= cmp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= burst_done;
      if (burst_done) result <= sar_q & keep_mask(mode8);
    end
  end

  assign trial = sar_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int unsigned RES_W        = 10,
  parameter int unsigned NARROW_W     = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SAMPLE_TICKS = 40,
  parameter int unsigned CONV_DIV     = 8,
  parameter int unsigned CONV_CYCLES  = 13,
  localparam int unsigned PW = $clog2(CONV_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             cs_n_i,
  input  logic             rd_cnv_i,
  input  logic             a0_i,
  input  logic             freq_norm_i,
  input  logic             cmp_i,
  output logic             hold_o,
  output logic             conv_clk_o,
  output logic [RES_W-1:0] trial_o,
  output logic             eoc_n_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o
);
  // Synchronized control bus: {freq, a0, rd_cnv, cs_n, ce}
  logic [4:0] ctl_s;
  logic       ce_s, cs_n_s, rd_s, a0_s, freq_s;
  logic       cond_now, cond_q;
  logic       start_evt;
  logic       busy, period_tick, burst_done, mode8;
  logic [PW-1:0] period_idx;

  sar_ctl_sync #(.STAGES(SYNC_STAGES), .NSIG(5), .RST_VAL(5'b10110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({freq_norm_i, a0_i, rd_cnv_i, cs_n_i, ce_i}),
    .sync_o(ctl_s)
  );

  assign {freq_s, a0_s, rd_s, cs_n_s, ce_s} = ctl_s;
  assign cond_now  = ce_s && !cs_n_s && !rd_s;
  assign start_evt = cond_now && !cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_now;
  end

  sar_burst_timer #(
    .SAMPLE_TICKS(SAMPLE_TICKS), .CONV_DIV(CONV_DIV), .CONV_CYCLES(CONV_CYCLES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .mode_sel(a0_s),
    .freq_norm(freq_s), .busy(busy), .hold(hold_o), .conv_clk(conv_clk_o),
    .period_tick(period_tick), .period_idx(period_idx),
    .burst_done(burst_done), .mode8(mode8)
  );

  sar_bit_engine #(
    .RES_W(RES_W), .NARROW_W(NARROW_W), .CONV_CYCLES(CONV_CYCLES)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .period_idx(period_idx),
    .burst_done(burst_done), .mode8(mode8), .cmp_i(cmp_i),
    .trial(trial_o), .result(result_o), .result_valid(result_valid_o)
  );

  assign eoc_n_o = busy;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned NARROW_W    = 8,
  parameter int unsigned CONV_CYCLES = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             mode8,
  input logic             hold_o,
  input logic             conv_clk_o,
  input logic             eoc_n_o,
  input logic [RES_W-1:0] result_o,
  input logic             result_valid_o
);
  localparam int unsigned CUT = RES_W - NARROW_W;
  logic       clk_seen_q;
  logic [7:0] rise_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_seen_q <= 1'b0;
      rise_cnt_q <= '0;
    end else begin
      clk_seen_q <= conv_clk_o;
      if (hold_o)                        rise_cnt_q <= '0;
      else if (conv_clk_o && !clk_seen_q) rise_cnt_q <= rise_cnt_q + 8'd1;
    end
  end

  assert_edge_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_n_o) |-> $past(start_evt));
  assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !eoc_n_o) |=> eoc_n_o);
  assert_hold_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> !hold_o);
  assert_hold_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> (eoc_n_o && !conv_clk_o));
  assert_clk_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_clk_o |-> eoc_n_o);
  assert_burst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (rise_cnt_q == 8'(CONV_CYCLES)));
  assert_valid_at_eoc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $fell(eoc_n_o));
  assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o));
  assert_narrow_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && mode8) |-> (result_o[CUT-1:0] == '0));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .RES_W(RES_W), .NARROW_W(NARROW_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .mode8(mode8),
  .hold_o(hold_o), .conv_clk_o(conv_clk_o), .eoc_n_o(eoc_n_o),
  .result_o(result_o), .result_valid_o(result_valid_o)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  localparam int SAMP = 40;
  localparam int DIV  = 8;
  localparam int NCYC = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, cs_n = 1'b1, rd = 1'b1, a0 = 1'b0, fnorm = 1'b1;
  logic [9:0] vin = '0;
  logic cmp;
  logic hold, cclk, eoc_n, valid;
  logic [9:0] trial, res;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;
  assign cmp = (vin >= trial);

  sar_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_n_i(cs_n), .rd_cnv_i(rd), .a0_i(a0),
    .freq_norm_i(fnorm), .cmp_i(cmp), .hold_o(hold), .conv_clk_o(cclk),
    .trial_o(trial), .eoc_n_o(eoc_n), .result_o(res), .result_valid_o(valid)
  );

  function automatic logic [9:0] exp_word(input logic [9:0] v, input logic narrow);
    return narrow ? {v[9:2], 2'b00} : v;
  endfunction

  function automatic int exp_busy(input logic fn);
    return SAMP + NCYC * (fn ? DIV : DIV / 2);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_conv(input logic [9:0] v, input logic narrow, input logic fn,
                          input int trig, input bit poke);
    int lat = 0, busy = 1, hold_at = 0, rises = 0, first_rise = 0, stray = 0;
    logic prev = 1'b0;
    logic [9:0] kept;
    vin = v; a0 = narrow; fnorm = fn;
    // put two lines active, last line completes the condition
    ce = (trig != 0); cs_n = (trig == 1); rd = (trig == 2);
    @(negedge clk);
    if (trig == 0) ce = 1'b1; else if (trig == 1) cs_n = 1'b0; else rd = 1'b0;
    do begin @(negedge clk); lat++; end while (!eoc_n && lat < 10);
    chk("R12 start latency", lat, 3);
    a0 = ~narrow;  // must not alter the running mode
    while (eoc_n && busy < 2000) begin
      if (hold) hold_at = busy;
      if (cclk && !prev) begin rises++; if (first_rise == 0) first_rise = busy; end
      prev = cclk;
      if (poke && busy == 5) rd = 1'b1;
      if (poke && busy == 9) rd = 1'b0;
      @(negedge clk);
      if (eoc_n) busy++;
    end
    chk("R9 valid at eoc fall", valid, 1);
    chk(narrow ? "R3 narrow result" : "R4 full result", res, exp_word(v, narrow));
    chk(fn ? "R7 busy length normal" : "R7 busy length fast", busy, exp_busy(fn));
    chk("R5 hold position", hold_at, SAMP);
    chk("R6 burst periods", rises, NCYC);
    chk("R6 clock after hold", int'(first_rise > hold_at), 1);
    kept = res;
    // condition stays true: no new conversion, result stable
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (eoc_n || valid || res != kept || cclk) stray++;
    end
    chk(poke ? "R11 busy edge ignored" : "R1 held condition no restart", stray, 0);
    ce = 1'b0; cs_n = 1'b1; rd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!done_flag && wd < 150000) begin @(posedge clk); wd++; end
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=finish", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int stray;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R10 reset result", res, 0);
    chk("R10 reset eoc_n", eoc_n, 0);
    chk("R10 reset strobes", {valid, hold, cclk}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    run_conv(10'd0,    1'b0, 1'b1, 0, 0);
    run_conv(10'h3FF,  1'b0, 1'b0, 1, 0);
    run_conv(10'h200,  1'b0, 1'b1, 2, 0);
    run_conv(10'h003,  1'b1, 1'b1, 2, 0);
    run_conv(10'h3FF,  1'b1, 1'b0, 0, 0);
    run_conv(10'h155,  1'b0, 1'b1, 2, 1);

    // partial conditions never start (R1)
    stray = 0;
    ce = 1'b0; cs_n = 1'b0; rd = 1'b0;
    repeat (8) begin @(negedge clk); if (eoc_n) stray++; end
    ce = 1'b1; cs_n = 1'b1;
    repeat (8) begin @(negedge clk); if (eoc_n) stray++; end
    cs_n = 1'b0; rd = 1'b1;
    repeat (8) begin @(negedge clk); if (eoc_n) stray++; end
    chk("R1 partial condition", stray, 0);
    ce = 1'b0; cs_n = 1'b1; rd = 1'b1;
    repeat (3) @(negedge clk);

    // random conversions (R2 mode latch, R4, R3, R7)
    for (int n = 0; n < 24; n++) begin
      run_conv(10'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    done_flag = 1;
    $finish;
  end
endmodule